// File: doc/BRIEF.md
# Snoop-Aware Bus Hold Arbiter

This block sits in the system logic beside a processor that has a write-back cache. Several external bus masters each raise their own request line. The arbiter asks the processor for the local bus by raising `hold`. Once the processor answers on `hlda`, the arbiter passes the bus to one master at a time through that master's own grant line. Masters are picked in rotating order. A master keeps the bus for as long as its request stays high. When no request is left, the arbiter drops `hold` and the processor takes the bus back.

The processor raises `hitm` when a snoop hits a modified line that it holds. That line must be written back before any master touches memory. The arbiter then keeps `hold` raised for at least one more clock and grants no master. It also answers the processor's own bus cycles at zero wait states, never in the cycle in which the cycle start, and with it `hitm`, is first sampled. Once the write-back burst ends with its last beat accepted, the waiting master is granted.

Top module: `snoop_hold_arbiter`

## Requirements
- R1: While `rst_n` is low, and at the first clock after reset, `hold`, every bit of `gnt` and `rdy` are 0.
- R2: In the idle state, any high bit of `req` makes `hold` go to 1 after the next rising clock edge.
- R3: A grant is issued only at a clock edge where `hold` is 1, `hlda` is 1, `hitm` is 0, no write-back is pending and no processor cycle is in progress. The grant appears on `gnt` after that edge.
- R4: The arbiter picks the requester that comes first after the previous winner, counting upward and wrapping around. After reset the previous winner counts as the highest index, so index 0 comes first. `gnt` bit i belongs to `req` bit i.
- R5: A granted master keeps its grant, whatever the other requests do, until it drops its request. The grant is then cleared after the next edge.
- R6: When a grant has been cleared and no request is pending, `hold` drops one clock later, unless R7 applies.
- R7: If `hitm` is 1 at an edge, `hold` is not dropped at that edge or at the one after it.
- R8: A processor cycle starts when `cyc_start` is 1 and no master is granted. `cyc_write` is 1 for a write and 0 for a read. `rdy` is 0 in the start cycle and first goes to 1 after that edge.
- R9: Zero wait states: `rdy` stays 1 on every clock of the cycle until an edge where `burst_last` is 1 together with `rdy`. `rdy` goes to 0 after that edge.
- R10: A `hitm` rising edge marks a write-back as pending. The pending mark is cleared only when a write cycle ends with `burst_last` and `rdy` both high. No grant is issued while the mark is set.
- R11: At most one bit of `gnt` is 1, and a grant is only ever high while `hold` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MASTERS | One bus request per external master |
| hlda | input | 1 | Processor acknowledges that it has released the bus |
| hitm | input | 1 | Snoop hit on a modified line in the processor cache |
| cyc_start | input | 1 | Processor starts a bus cycle |
| cyc_write | input | 1 | Direction of the starting cycle: 1 write, 0 read |
| burst_last | input | 1 | Processor marks the final beat of its burst |
| hold | output | 1 | Bus request to the processor |
| gnt | output | N_MASTERS | One-hot bus grant, one bit per master |
| rdy | output | 1 | Data-ready answer to the processor |

## Verification
Every output is a register or a direct copy of one. An input applied just after one rising edge therefore shows its effect right after the following edge. This holds for `hold` from a request, for a grant or its removal, and for `rdy` from a cycle start or a last beat. `hold` drops exactly one edge after the grant clears. When `hitm` was high, the drop comes one edge later still. For each stimulus, the driver queues the expected `hold`, `gnt` and `rdy` tagged with the cycle number one edge ahead. The monitor compares them at the falling edge of that cycle. Any item whose cycle has passed without a match counts as a failure.

// File: rtl/snoop_hold_arbiter_pkg.sv
package snoop_hold_arbiter_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;

  // next index after 'prev' counting 'step' positions, modulo n
  function automatic int rr_index(input int prev, input int step, input int n);
    return (prev + step) % n;
  endfunction

endpackage

// File: rtl/hold_rr_pick.sv
module hold_rr_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] prev_idx,
  output logic [IW-1:0] win_idx,
  output logic          win_vld
);
  import snoop_hold_arbiter_pkg::*;

  // scan from farthest to nearest so the nearest requester after prev wins
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int k = N; k >= 1; k--) begin
      if (req[rr_index(int'(prev_idx), k, N)]) begin
        win_vld = 1'b1;
        win_idx = IW'(rr_index(int'(prev_idx), k, N));
      end
    end
  end

endmodule

// File: rtl/hold_snoop_guard.sv
module hold_snoop_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic hitm,
  input  logic wr_burst_end,
  output logic hitm_rise,
  output logic hold_keep,
  output logic wb_pend
);
  logic hitm_q;

  assign hitm_rise = hitm & ~hitm_q;
  assign hold_keep = hitm | hitm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitm_q  <= 1'b0;
      wb_pend <= 1'b0;
    end else begin
      hitm_q  <= hitm;
      wb_pend <= (wb_pend | hitm_rise) & ~wr_burst_end;
    end
  end

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hitm_rise |=> wb_pend) else $error("pending mark not set"); // R10

endmodule

// File: rtl/hold_cycle_track.sv
module hold_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_write,
  input  logic burst_last,
  input  logic cpu_owns,
  output logic busy,
  output logic rdy,
  output logic burst_end,
  output logic wr_burst_end
);
  logic is_wr;

  assign rdy          = busy;
  assign burst_end    = busy & burst_last;
  assign wr_burst_end = burst_end & is_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      is_wr <= 1'b0;
    end else if (burst_end) begin
      busy  <= 1'b0;
    end else if (!busy && cyc_start && cpu_owns) begin
      busy  <= 1'b1;
      is_wr <= cyc_write;
    end
  end

  AST_RDY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(cyc_start)) else $error("rdy without start"); // R8
  AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && !burst_last |=> rdy) else $error("wait state inserted"); // R9
  AST_RDY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rdy && burst_last |=> !rdy) else $error("rdy past last beat"); // R9

endmodule

// File: rtl/snoop_hold_arbiter.sv
module snoop_hold_arbiter #(
  parameter int N_MASTERS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 hlda,
  input  logic                 hitm,
  input  logic                 cyc_start,
  input  logic                 cyc_write,
  input  logic                 burst_last,
  output logic                 hold,
  output logic [N_MASTERS-1:0] gnt,
  output logic                 rdy
);
  import snoop_hold_arbiter_pkg::*;

  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

  arb_state_e           state_q;
  logic [N_MASTERS-1:0] gnt_q;
  logic [IW-1:0]        owner_q;
  logic [IW-1:0]        prev_q;
  logic [IW-1:0]        win_idx;
  logic                 win_vld;
  logic                 hitm_rise, hold_keep, wb_pend;
  logic                 busy, burst_end, wr_burst_end;
  logic                 grant_ok;
  logic                 owner_drop;
  logic                 any_req;

  hold_rr_pick #(.N(N_MASTERS), .IW(IW)) u_pick (
    .req      (req),
    .prev_idx (prev_q),
    .win_idx  (win_idx),
    .win_vld  (win_vld)
  );

  hold_snoop_guard u_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .hitm         (hitm),
    .wr_burst_end (wr_burst_end),
    .hitm_rise    (hitm_rise),
    .hold_keep    (hold_keep),
    .wb_pend      (wb_pend)
  );

  hold_cycle_track u_cyc (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_start    (cyc_start),
    .cyc_write    (cyc_write),
    .burst_last   (burst_last),
    .cpu_owns     (gnt_q == '0),
    .busy         (busy),
    .rdy          (rdy),
    .burst_end    (burst_end),
    .wr_burst_end (wr_burst_end)
  );

  assign any_req    = |req;
  assign grant_ok   = win_vld & hlda & ~hitm & ~wb_pend & ~busy;
  assign owner_drop = ~req[owner_q];
  assign hold       = (state_q != ARB_IDLE);
  assign gnt        = gnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      gnt_q   <= '0;
      owner_q <= '0;
      prev_q  <= IW'(N_MASTERS - 1);
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (any_req) state_q <= ARB_WAIT;
        end
        ARB_WAIT: begin
          if (grant_ok) begin
            state_q <= ARB_OWN;
            gnt_q   <= N_MASTERS'(1) << win_idx;
            owner_q <= win_idx;
            prev_q  <= win_idx;
          end else if (!any_req && !hold_keep) begin
            state_q <= ARB_IDLE;
          end
        end
        ARB_OWN: begin
          if (owner_drop) begin
            state_q <= ARB_WAIT;
            gnt_q   <= '0;
          end
        end
        default: begin
          state_q <= ARB_IDLE;
          gnt_q   <= '0;
        end
      endcase
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)) else $error("several grants"); // R11
  AST_GNT_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> hold) else $error("grant without hold"); // R11
  AST_GNT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gnt) |-> $past(hlda && !hitm && !wb_pend && !busy)) else $error("unsafe grant"); // R3
  AST_GNT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req)) |=> $stable(gnt)) else $error("grant taken away"); // R5
  AST_HOLD_AFTER_HITM: assert property (@(posedge clk) disable iff (!rst_n)
    hold && hitm |=> hold) else $error("hold dropped on hitm"); // R7
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> !$past(|gnt)) else $error("hold dropped under grant"); // R6
  AST_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !hold && any_req |=> hold) else $error("request ignored"); // R2

endmodule

// File: tb/sim_snoop_hold_arbiter.sv
module sim_snoop_hold_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         hlda = 1'b0, hitm = 1'b0, cyc_start = 1'b0, cyc_write = 1'b0, burst_last = 1'b0;
  logic         hold, rdy;
  logic [N-1:0] gnt;

  typedef struct {
    int           due;
    logic         hold;
    logic [N-1:0] gnt;
    logic         rdy;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done = 1'b0;

  snoop_hold_arbiter #(.N_MASTERS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .hlda(hlda), .hitm(hitm),
    .cyc_start(cyc_start), .cyc_write(cyc_write), .burst_last(burst_last),
    .hold(hold), .gnt(gnt), .rdy(rdy)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // driver: apply inputs just after an edge, expect the result after the next one
  task automatic step(input logic [N-1:0] r, input logic a, input logic h,
                      input logic s, input logic w, input logic l,
                      input logic e_hold, input logic [N-1:0] e_gnt,
                      input logic e_rdy, input string tag);
    exp_t it;
    @(posedge clk);
    #1;
    req = r; hlda = a; hitm = h; cyc_start = s; cyc_write = w; burst_last = l;
    it.due = cyc + 1; it.hold = e_hold; it.gnt = e_gnt; it.rdy = e_rdy; it.tag = tag;
    q.push_back(it);
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      n_chk++;
      if (it.due < cyc) begin
        n_err++;
        $display("FAIL %s: item missed, due %0d now %0d", it.tag, it.due, cyc);
      end else if (hold !== it.hold || gnt !== it.gnt || rdy !== it.rdy) begin
        n_err++;
        $display("FAIL %s: hold=%b gnt=%b rdy=%b expected hold=%b gnt=%b rdy=%b",
                 it.tag, hold, gnt, rdy, it.hold, it.gnt, it.rdy);
      end
    end
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (hold !== 1'b0 || gnt !== '0 || rdy !== 1'b0) begin
      n_err++;
      $display("FAIL R1: in reset hold=%b gnt=%b rdy=%b expected 0 0000 0", hold, gnt, rdy);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    //    req     hlda hitm st wr last  hold gnt     rdy
    step(4'b0000, 0, 0, 0, 0, 0,   0, 4'b0000, 0, "R1 after reset");
    step(4'b0101, 0, 0, 0, 0, 0,   1, 4'b0000, 0, "R2 request raises hold");
    step(4'b0101, 0, 0, 0, 0, 0,   1, 4'b0000, 0, "R3 no grant without hlda");
    step(4'b0101, 1, 0, 0, 0, 0,   1, 4'b0001, 0, "R4 first winner index 0");
    step(4'b0101, 1, 0, 0, 0, 0,   1, 4'b0001, 0, "R5 grant held");
    step(4'b0100, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 grant cleared on drop");
    step(4'b0100, 1, 0, 0, 0, 0,   1, 4'b0100, 0, "R4 next winner index 2");
    step(4'b0000, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 grant cleared");
    step(4'b0000, 1, 0, 0, 0, 0,   0, 4'b0000, 0, "R6 hold drops one later");
    step(4'b0101, 0, 0, 0, 0, 0,   1, 4'b0000, 0, "R2 hold again");
    step(4'b0101, 1, 0, 0, 0, 0,   1, 4'b0001, 0, "R4 wrap to index 0");
    step(4'b0100, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 drop");
    step(4'b0100, 1, 0, 0, 0, 0,   1, 4'b0100, 0, "R4 index 2");
    step(4'b1100, 1, 0, 0, 0, 0,   1, 4'b0100, 0, "R5 newcomer does not preempt");
    step(4'b1000, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 drop");
    step(4'b1000, 1, 0, 0, 0, 0,   1, 4'b1000, 0, "R4 index 3");
    step(4'b0000, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 drop");
    step(4'b0000, 1, 0, 0, 0, 0,   0, 4'b0000, 0, "R6 hold drops");
    // snoop hit while a master waits
    step(4'b0010, 0, 0, 0, 0, 0,   1, 4'b0000, 0, "R2 hold for master 1");
    step(4'b0010, 1, 1, 0, 0, 0,   1, 4'b0000, 0, "R3 hitm blocks grant");
    step(4'b0010, 0, 1, 1, 1, 0,   1, 4'b0000, 1, "R8 write-back starts, rdy after edge");
    step(4'b0010, 1, 0, 0, 1, 0,   1, 4'b0000, 1, "R10 pending blocks grant");
    step(4'b0010, 1, 0, 0, 1, 1,   1, 4'b0000, 0, "R9 last beat ends rdy");
    step(4'b0010, 1, 0, 0, 0, 0,   1, 4'b0010, 0, "R10 grant after write-back");
    step(4'b0000, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 drop");
    step(4'b0000, 1, 1, 0, 0, 0,   1, 4'b0000, 0, "R7 hold kept while hitm");
    step(4'b0000, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R7 hold kept one more clock");
    step(4'b0000, 0, 0, 0, 0, 0,   0, 4'b0000, 0, "R6 hold drops after guard");
    step(4'b0000, 0, 0, 1, 1, 0,   0, 4'b0000, 1, "R8 write cycle start");
    step(4'b0000, 0, 0, 0, 1, 1,   0, 4'b0000, 0, "R9 single beat write");
    step(4'b0000, 0, 0, 1, 0, 0,   0, 4'b0000, 1, "R8 read cycle start");
    step(4'b0000, 0, 0, 0, 0, 0,   0, 4'b0000, 1, "R9 zero wait beat");
    step(4'b0000, 0, 0, 0, 0, 0,   0, 4'b0000, 1, "R9 zero wait beat");
    step(4'b0000, 0, 0, 0, 0, 1,   0, 4'b0000, 0, "R9 read burst ends");
    step(4'b0001, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R2 hold");
    step(4'b0001, 1, 0, 0, 0, 0,   1, 4'b0001, 0, "R11 single grant after clear pending");
    step(4'b0000, 1, 0, 0, 0, 0,   1, 4'b0000, 0, "R5 drop");
    step(4'b0000, 1, 0, 0, 0, 0,   0, 4'b0000, 0, "R6 hold drops");
    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule